// File: doc/BRIEF.md
# NAND flash register-window bridge

The bridge places a row of 16-bit registers on a request/acknowledge host bus and turns each access into one bus cycle on a shared 8-bit raw NAND flash interface. It serves up to four devices. Host software writes a command byte to one of four command registers, and the register it writes picks the device. It then writes address bytes and moves data bytes through the data register. To wait for a device, it reads the address register, and that read does not complete until the device's ready/busy line shows ready. A write to the terminate register releases every chip enable. ECC, command sequencing and bad-block handling remain in software. Only the low byte of each bus word carries NAND data.

A single state machine runs every access:

- **IDLE** decodes the request.
  - A command, address or data access goes to **SETUP**.
  - A read of the address register goes to **WAIT_RB**.
  - A terminate, an unused offset, or a read of a write-only register goes straight to **ACK**.
- **SETUP** drives CLE/ALE and the output byte for one cycle with both strobes high. It then goes to **STROBE**.
- **STROBE** holds the write or read strobe low for `PULSE_W` cycles and then goes to **HOLD**.
- **HOLD** keeps CLE/ALE and the byte for `HOLD_W` cycles and then goes to **ACK**.
- **WAIT_RB** stays until the synchronised ready line of the selected device is high, then goes to **ACK**.
- **ACK** gives a one-cycle acknowledge and returns to **IDLE**.

Top module: `nflash_bridge`

## Requirements
- R1: After reset all chip-enable outputs are high, the write and read strobes are high, CLE and ALE are low, and acknowledge is low.
- R2: A write to halfword index i (i = 0 to 3, byte offset 2·i) sends one command cycle: CLE is high, ALE is low, chip enable i is low during the write strobe, and the byte is wdata[7:0].
- R3: Chip enable i stays low through later address and data accesses. It moves to device j when command register j is written. At most one chip enable is low at any time.
- R4: A write to byte offset 0x8 sends one address cycle: ALE is high, CLE is low, and the byte is wdata[7:0]. The selected device is unchanged.
- R5: A write to byte offset 0x10 sends one data-in cycle with CLE and ALE low. Bits 15:8 of wdata have no effect on the byte driven.
- R6: A read of byte offset 0x10 pulses the read strobe once and returns the NAND byte in rdata[7:0], with rdata[15:8] zero.
- R7: A read of byte offset 0x8 is not acknowledged while the selected device's ready/busy input (1 = ready) is low. After that input goes high, it is acknowledged within 6 cycles, including the two-flop synchroniser.
- R8: A write of any value to byte offset 0xA raises all chip enables by the time it is acknowledged.
- R9: Accesses to unused offsets (0xC, 0xE, 0x12 and above) are acknowledged within 3 cycles of the request. They cause no strobe and no change of chip enable, and reads of them return zero.
- R10: Each strobe is low for exactly PULSE_W cycles. CLE, ALE and the output byte are set at least one cycle before the strobe falls and are held at least one cycle after it rises. Write and read strobes are never low together.
- R11: Acknowledge is never high while a write or read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Access request, held until acknowledge |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Byte offset in the register window |
| host_wdata | input | 16 | Write data; bits 7:0 used |
| host_rdata | output | 16 | Read data, valid with acknowledge |
| host_ack | output | 1 | One-cycle access completion |
| nand_io_out | output | 8 | Byte driven to the NAND bus |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Byte read from the NAND bus |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 4 | Chip enables, active low, one per device |
| nand_rb | input | 4 | Ready/busy per device, 1 = ready |

## Verification
The hardest case is the blocking wait. The bench must hold a read of the address register pending while the selected device is busy, and other devices must show ready at the same time so that a wrong index would give the game away. The stimulus selects device 2 through its command register and drives only that device's ready line low. It then leaves the wait read outstanding for 25 cycles while watching that acknowledge stays low. Finally it releases the line and measures the cycles to acknowledge, which shows the synchroniser delay as well as the stall.

// File: rtl/nfb_pkg.sv
package nfb_pkg;
    typedef enum logic [2:0] {
        ACC_CMD,
        ACC_ADDR,
        ACC_WAIT,
        ACC_TERM,
        ACC_DWR,
        ACC_DRD,
        ACC_NONE
    } acc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_WAITRB,
        ST_ACK
    } st_e;

    localparam int IDX_ADDR = 4;
    localparam int IDX_TERM = 5;
    localparam int IDX_DATA = 8;
endpackage

// File: rtl/nfb_decode.sv
module nfb_decode
    import nfb_pkg::*;
#(
    parameter int HW_W      = 4,
    parameter int NUM_CHIPS = 4,
    localparam int CHIP_W   = $clog2(NUM_CHIPS)
) (
    input  logic              we,
    input  logic [HW_W-1:0]   hw_idx,
    output acc_e              acc,
    output logic [CHIP_W-1:0] chip
);
    always_comb begin
        chip = hw_idx[CHIP_W-1:0];
        if (int'(hw_idx) < NUM_CHIPS)
            acc = we ? ACC_CMD : ACC_NONE;
        else if (int'(hw_idx) == IDX_ADDR)
            acc = we ? ACC_ADDR : ACC_WAIT;
        else if (int'(hw_idx) == IDX_TERM)
            acc = we ? ACC_TERM : ACC_NONE;
        else if (int'(hw_idx) == IDX_DATA)
            acc = we ? ACC_DWR : ACC_DRD;
        else
            acc = ACC_NONE;
    end
endmodule

// File: rtl/nfb_rb_sync.sv
module nfb_rb_sync #(
    parameter int NUM_CHIPS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CHIPS-1:0] rb_async,
    output logic [NUM_CHIPS-1:0] rb_sync
);
    for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_sync
        logic meta_q, out_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                out_q  <= 1'b0;
            end else begin
                meta_q <= rb_async[g];
                out_q  <= meta_q;
            end
        end
        assign rb_sync[g] = out_q;
    end
endmodule

// File: rtl/nfb_cycle_timer.sv
module nfb_cycle_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end
    assign done = (cnt_q == '0);
endmodule

// File: rtl/nflash_bridge.sv
module nflash_bridge
    import nfb_pkg::*;
#(
    parameter int NUM_CHIPS = 4,
    parameter int ADDR_W    = 5,
    parameter int BUS_W     = 16,
    parameter int IO_W      = 8,
    parameter int PULSE_W   = 3,
    parameter int HOLD_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_req,
    input  logic                 host_we,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [BUS_W-1:0]     host_wdata,
    output logic [BUS_W-1:0]     host_rdata,
    output logic                 host_ack,
    output logic [IO_W-1:0]      nand_io_out,
    output logic                 nand_io_oe,
    input  logic [IO_W-1:0]      nand_io_in,
    output logic                 nand_cle,
    output logic                 nand_ale,
    output logic                 nand_we_n,
    output logic                 nand_re_n,
    output logic [NUM_CHIPS-1:0] nand_ce_n,
    input  logic [NUM_CHIPS-1:0] nand_rb
);
    // NUM_CHIPS must be 2..4 (command registers sit below the address register)
    localparam int CHIP_W = $clog2(NUM_CHIPS);
    localparam int HW_W   = ADDR_W - 1;
    localparam int TMAX   = (PULSE_W > HOLD_W) ? PULSE_W : HOLD_W;
    localparam int TW     = $clog2(TMAX + 1);

    st_e                 state_q, state_d;
    acc_e                dec_acc, acc_q;
    logic [CHIP_W-1:0]   dec_chip, sel_q;
    logic [NUM_CHIPS-1:0] ce_q, rb_s;
    logic [IO_W-1:0]     wbyte_q;
    logic [BUS_W-1:0]    rdata_q;
    logic                tmr_load, tmr_done;
    logic [TW-1:0]       tmr_val;
    logic                start;

    wire unused_bits = ^{host_wdata[BUS_W-1:IO_W], host_addr[0]};

    nfb_decode #(.HW_W(HW_W), .NUM_CHIPS(NUM_CHIPS)) dec_i (
        .we     (host_we),
        .hw_idx (host_addr[ADDR_W-1:1]),
        .acc    (dec_acc),
        .chip   (dec_chip)
    );

    nfb_rb_sync #(.NUM_CHIPS(NUM_CHIPS)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_async (nand_rb),
        .rb_sync  (rb_s)
    );

    nfb_cycle_timer #(.W(TW)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign start = (state_q == ST_IDLE) && host_req;

    // next state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    unique case (dec_acc)
                        ACC_CMD, ACC_ADDR, ACC_DWR, ACC_DRD: state_d = ST_SETUP;
                        ACC_WAIT:                            state_d = ST_WAITRB;
                        default:                             state_d = ST_ACK;
                    endcase
                end
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                tmr_val  = TW'(PULSE_W - 1);
                state_d  = ST_STROBE;
            end
            ST_STROBE: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HOLD_W - 1);
                    state_d  = ST_HOLD;
                end
            end
            ST_HOLD:   if (tmr_done) state_d = ST_ACK;
            ST_WAITRB: if (rb_s[sel_q]) state_d = ST_ACK;
            ST_ACK:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // latched access context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= ACC_NONE;
            sel_q   <= '0;
            ce_q    <= '0;
            wbyte_q <= '0;
            rdata_q <= '0;
        end else begin
            if (start) begin
                acc_q   <= dec_acc;
                wbyte_q <= host_wdata[IO_W-1:0];
                rdata_q <= '0;
                if (dec_acc == ACC_CMD) begin
                    sel_q <= dec_chip;
                    ce_q  <= NUM_CHIPS'(1) << dec_chip;
                end else if (dec_acc == ACC_TERM) begin
                    ce_q  <= '0;
                end
            end
            if (state_q == ST_STROBE && tmr_done && acc_q == ACC_DRD)
                rdata_q <= BUS_W'(nand_io_in);
        end
    end

    // outputs
    always_comb begin
        logic in_cyc, is_rd;
        in_cyc      = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
        is_rd       = (acc_q == ACC_DRD);
        nand_cle    = in_cyc && (acc_q == ACC_CMD);
        nand_ale    = in_cyc && (acc_q == ACC_ADDR);
        nand_we_n   = !((state_q == ST_STROBE) && !is_rd);
        nand_re_n   = !((state_q == ST_STROBE) && is_rd);
        nand_io_oe  = in_cyc && !is_rd;
        nand_io_out = wbyte_q;
        nand_ce_n   = ~ce_q;
        host_ack    = (state_q == ST_ACK);
        host_rdata  = rdata_q;
    end
endmodule

// File: rtl/nfb_checker.sv
module nfb_checker #(
    parameter int NUM_CHIPS = 4,
    parameter int HW_W      = 4,
    parameter int IO_W      = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 host_req,
    input logic                 host_we,
    input logic [HW_W-1:0]      host_hw,
    input logic                 host_ack,
    input logic                 nand_cle,
    input logic                 nand_ale,
    input logic                 nand_we_n,
    input logic                 nand_re_n,
    input logic [IO_W-1:0]      nand_io_out,
    input logic [NUM_CHIPS-1:0] nand_ce_n
);
    a_r11_ack_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> (nand_we_n && nand_re_n));

    a_r3_one_chip: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~nand_ce_n));

    a_r10_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    a_r4_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    a_r10_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && !$past(nand_we_n)) |-> $stable(nand_io_out));

    a_r10_cle_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_we_n) |-> ($past(nand_cle) == nand_cle && $past(nand_ale) == nand_ale));

    a_r10_cle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> ($past(nand_cle) == nand_cle && $past(nand_ale) == nand_ale));

    a_r8_term_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && host_req && host_we && int'(host_hw) == 5) |-> (&nand_ce_n));
endmodule

bind nflash_bridge nfb_checker #(
    .NUM_CHIPS(NUM_CHIPS), .HW_W(ADDR_W - 1), .IO_W(IO_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_hw     (host_addr[ADDR_W-1:1]),
    .host_ack    (host_ack),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_io_out (nand_io_out),
    .nand_ce_n   (nand_ce_n)
);

// File: tb/nflash_bridge_tb_top.sv
module nflash_bridge_tb_top;
    localparam int PULSE_W = 3;
    localparam int HOLD_W  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_ack;
    logic [7:0]  nand_io_out, nand_io_in;
    logic        nand_io_oe, nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic [3:0]  nand_ce_n;
    logic [3:0]  nand_rb = 4'hF;
    logic [7:0]  flash_byte = 8'h00;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic       cle;
        logic       ale;
        logic [3:0] ce_n;
        logic [7:0] b;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;
    assign nand_io_in = flash_byte;

    nflash_bridge #(.PULSE_W(PULSE_W), .HOLD_W(HOLD_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ack(host_ack), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
        .nand_io_in(nand_io_in), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n),
        .nand_rb(nand_rb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // monitor: compares every write strobe against the scoreboard
    logic prev_we = 1'b1, prev_re = 1'b1, prev_cle = 1'b0, prev_ale = 1'b0;
    int   we_low = 0, re_low = 0, re_pulses = 0;
    exp_t snap;
    always @(negedge clk) begin
        if (host_ack && (!nand_we_n || !nand_re_n))
            chk(1'b0, "R11 ack during strobe", 1, 0);
        if (prev_we && !nand_we_n)
            chk(prev_cle == nand_cle && prev_ale == nand_ale, "R10 setup of CLE/ALE",
                {prev_cle, prev_ale}, {nand_cle, nand_ale});
        if (!nand_we_n) begin
            we_low++;
            snap = '{nand_cle, nand_ale, nand_ce_n, nand_io_out};
        end
        if (!prev_we && nand_we_n) begin
            chk(we_low == PULSE_W, "R10 write strobe width", we_low, PULSE_W);
            chk(nand_cle == snap.cle && nand_ale == snap.ale, "R10 hold of CLE/ALE",
                {nand_cle, nand_ale}, {snap.cle, snap.ale});
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected write strobe", int'(snap), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(snap == e, "R2/R3/R4/R5 NAND cycle", int'(snap), int'(e));
            end
            we_low = 0;
        end
        if (!nand_re_n) re_low++;
        if (!prev_re && nand_re_n) begin
            chk(re_low == PULSE_W, "R10 read strobe width", re_low, PULSE_W);
            re_pulses++;
            re_low = 0;
        end
        prev_we  = nand_we_n;
        prev_re  = nand_re_n;
        prev_cle = nand_cle;
        prev_ale = nand_ale;
    end

    task automatic access(input bit we, input logic [4:0] a, input logic [15:0] d,
                          output logic [15:0] rd, output int cyc);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        cyc = 0;
        rd  = '0;
        while (cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (host_ack) begin
                rd = host_rdata;
                break;
            end
        end
        host_req = 1'b0;
    endtask

    task automatic wr_expect(input logic [4:0] a, input logic [15:0] d, input exp_t e);
        logic [15:0] rd;
        int cyc;
        exp_q.push_back(e);
        access(1'b1, a, d, rd, cyc);
    endtask

    initial begin : watchdog
        #(20 * 20000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [15:0] rd;
        int cyc, pulses0;
        bit early;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(nand_ce_n == 4'hF && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !host_ack,
            "R1 reset outputs", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 8'hFC);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 command cycles to each device, upper data bits set
        for (int i = 0; i < 4; i++) begin
            wr_expect(5'(2 * i), 16'hFF70 + 16'(i), '{1'b1, 1'b0, ~(4'b1 << i), 8'h70 + 8'(i)});
            chk(nand_ce_n == ~(4'b1 << i), "R2 chip enable follows command register",
                nand_ce_n, ~(4'b1 << i));
        end

        // R3/R4/R5 device 1 stays selected through address and data
        wr_expect(5'h2, 16'h0000, '{1'b1, 1'b0, 4'b1101, 8'h00});
        wr_expect(5'h8, 16'h1211, '{1'b0, 1'b1, 4'b1101, 8'h11});
        wr_expect(5'h8, 16'h0022, '{1'b0, 1'b1, 4'b1101, 8'h22});
        wr_expect(5'h8, 16'hEE33, '{1'b0, 1'b1, 4'b1101, 8'h33});
        chk(nand_ce_n == 4'b1101, "R4 address keeps device", nand_ce_n, 4'b1101);
        wr_expect(5'h10, 16'hA55C, '{1'b0, 1'b0, 4'b1101, 8'h5C});
        chk(nand_ce_n == 4'b1101, "R3 enable held after data", nand_ce_n, 4'b1101);

        // R6 data reads
        pulses0 = re_pulses;
        flash_byte = 8'hC3;
        access(1'b0, 5'h10, 16'hFFFF, rd, cyc);
        chk(rd == 16'h00C3, "R6 read byte 0xC3", rd, 16'h00C3);
        flash_byte = 8'h3C;
        access(1'b0, 5'h10, 16'h0, rd, cyc);
        chk(rd == 16'h003C, "R6 read byte 0x3C", rd, 16'h003C);
        chk(re_pulses == pulses0 + 2, "R6 one read strobe per read", re_pulses - pulses0, 2);

        // R7 wait on a ready device
        access(1'b0, 5'h8, 16'h0, rd, cyc);
        chk(cyc <= 6, "R7 wait on ready device", cyc, 6);

        // R7 wait on busy device 2 while others are ready
        wr_expect(5'h4, 16'h0090, '{1'b1, 1'b0, 4'b1011, 8'h90});
        nand_rb = 4'b1011;
        repeat (3) @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = 5'h8;
        early = 1'b0;
        for (int k = 0; k < 25; k++) begin
            @(negedge clk);
            if (host_ack) early = 1'b1;
        end
        chk(!early, "R7 no acknowledge while busy", early, 0);
        nand_rb = 4'hF;
        cyc = 0;
        while (cyc < 50) begin
            @(negedge clk);
            cyc++;
            if (host_ack) break;
        end
        host_req = 1'b0;
        chk(cyc <= 6, "R7 acknowledge after ready", cyc, 6);

        // R9 unused offsets
        access(1'b1, 5'hC, 16'h00AA, rd, cyc);
        chk(cyc <= 3, "R9 unused write quick ack", cyc, 3);
        access(1'b1, 5'hE, 16'h00BB, rd, cyc);
        access(1'b1, 5'h12, 16'h00CC, rd, cyc);
        chk(nand_ce_n == 4'b1011, "R9 unused writes keep enable", nand_ce_n, 4'b1011);
        access(1'b0, 5'hC, 16'h0, rd, cyc);
        chk(rd == 16'h0 && cyc <= 3, "R9 unused read returns zero", rd, 0);
        access(1'b0, 5'h1E, 16'h0, rd, cyc);
        chk(rd == 16'h0, "R9 high unused read returns zero", rd, 0);

        // R8 terminate
        access(1'b1, 5'hA, 16'h1234, rd, cyc);
        chk(nand_ce_n == 4'hF, "R8 terminate releases enables", nand_ce_n, 4'hF);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all expected cycles seen", exp_q.size(), 0);
        chk(1'b1, "R11 monitored throughout", 1, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule